// File: doc/BRIEF.md
# Receive Packet Channel Router

This block sits on the user side of a PCIe transaction-layer receive port. Packets arrive as 256-bit beats. Each beat carries a start flag, an end flag and an 8-bit dword-valid mask. The start beat also carries a one-hot code naming the target base address register and two error flags. The block steers every beat of a packet to one of up to six downstream channels, one per BAR. It discards whole packets that are flagged bad or that name no usable BAR, and counts the unusable BAR codes in a saturating counter.

The block does not buffer. It places the beat on a shared data bus and raises exactly one channel-valid line. It asks the upstream port to hold the beat, through a wait output, while the target channel is not ready. It also classifies the start beat as posted, non-posted or completion. It watches the non-posted buffer fill level of every channel and drives a hold-off request that lets the upstream port stop non-posted traffic while completions keep flowing. That request changes only between packets.

Top module: `rx_bar_router`

## Requirements
- R1: The outputs `out_data`, `out_dv`, `out_sop` and `out_eop` follow the inputs in the same cycle. Mask bit k qualifies data bits [32k+31:32k].
- R2: A beat is present only when `in_dv` is nonzero. With no beat present, `ch_vld` is all zero and `in_wait` is low.
- R3: For a start beat whose `in_bar` has exactly one usable bit n set, `ch_vld` is one-hot with bit n set. `ch_vld` never has more than one bit set.
- R4: The channel chosen on the accepted start beat is kept until the accepted end beat. Changes of `in_bar` on later beats are ignored.
- R5: If either `in_err` bit is set on the start beat, the whole packet is discarded: no `ch_vld` and no `in_wait` on any of its beats. Bit 0 flags an end-to-end CRC error and bit 1 flags a malformed packet.
- R6: An `in_bar` code with zero bits set or several bits set is unroutable. So is a code with odd bit 2k+1 set while `WIDE_BARS[k]` marks BAR 2k as 64-bit. An unroutable packet is discarded, and its accepted start beat increments `bad_bar_cnt`. The counter saturates at all ones.
- R7: `in_wait` is high exactly when a beat is present, is not being discarded, and its target channel's `ch_rdy` is low. A beat transfers in a cycle where it is present and `in_wait` is low; otherwise the source holds it.
- R8: `out_np` is high on a present start beat whose first dword is non-posted. Type field [28:24] and format field [31:29] decide this. Types 0101x (completions) and 10xxx (messages) are not non-posted. Neither is type 00000 with bit 30 set (memory write). Every other type is non-posted.
- R9: `np_mask` is registered. It sets when any channel's non-posted fill is at least `NP_AF`. It clears when every fill is below `NP_AF - NP_HYST`. It may change only on an edge where no packet is open.
- R10: After reset, `np_mask` is 0, `bad_bar_cnt` is 0 and no packet is open.
- R11: A beat without a start flag that arrives while no packet is open is discarded and not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_data | input | 256 | Beat data |
| in_dv | input | 8 | Per-dword valid mask |
| in_bar | input | 6 | One-hot target BAR code (start beat) |
| in_err | input | 2 | Error flags (start beat) |
| in_wait | output | 1 | Hold the current beat |
| np_mask | output | 1 | Request to hold off non-posted packets |
| ch_rdy | input | 6 | Per-channel ready |
| ch_np_fill | input | 36 | Per-channel non-posted fill, 6 bits each |
| ch_vld | output | 6 | One-hot channel valid |
| out_sop | output | 1 | Start flag to channels |
| out_eop | output | 1 | End flag to channels |
| out_data | output | 256 | Data to channels |
| out_dv | output | 8 | Dword mask to channels |
| out_np | output | 1 | Start beat is non-posted |
| bad_bar_cnt | output | 8 | Saturating unroutable-packet count |

## Verification
The bench changes `in_bar` in the middle of packets. A router that re-decodes each beat would split those packets across channels. It sends packets with error flags while every channel is stalled; a design that still consulted readiness would raise `in_wait` on traffic it should silently drain. It uses the code for the odd BAR beside a 64-bit BAR, sends more than 255 unroutable packets, and changes the buffer fill levels while a packet is open. These cases catch a design that routes to the odd BAR beside a 64-bit one, a counter that wraps, and a mask that moves partway through a packet.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int unsigned DWORD_W  = 32;
    localparam int unsigned MAX_CH   = 8;
    localparam int unsigned CH_IDX_W = $clog2(MAX_CH);

    // header field positions inside the first dword
    localparam int unsigned FMT_LSB  = 29;
    localparam int unsigned TYPE_LSB = 24;

    typedef enum logic [1:0] {
        CLS_POSTED     = 2'd0,
        CLS_NONPOSTED  = 2'd1,
        CLS_COMPLETION = 2'd2
    } tlp_cls_e;

    typedef struct packed {
        logic                drop;
        logic                bad_bar;
        logic [CH_IDX_W-1:0] ch;
    } route_t;

    function automatic tlp_cls_e classify(input logic [DWORD_W-1:0] dw0);
        logic [2:0] fmt;
        logic [4:0] typ;
        fmt = dw0[FMT_LSB +: 3];
        typ = dw0[TYPE_LSB +: 5];
        if (typ[4:1] == 4'b0101)
            return CLS_COMPLETION;
        else if (typ[4:3] == 2'b10)
            return CLS_POSTED;
        else if (typ == 5'b00000 && fmt[1])
            return CLS_POSTED;
        else
            return CLS_NONPOSTED;
    endfunction

endpackage

// File: rtl/rxr_bar_decode.sv
module rxr_bar_decode
    import rxr_pkg::*;
#(
    parameter int unsigned NUM_CH = 6,
    parameter int unsigned NPAIR  = (NUM_CH + 1) / 2,
    parameter logic [NPAIR-1:0] WIDE_BARS = '0
) (
    input  logic [NUM_CH-1:0] bar,
    input  logic [1:0]        err,
    output route_t            rt
);

    logic [NUM_CH-1:0] dead_bit;

    // an odd BAR whose even partner is 64-bit can never be a target
    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_dead
        if ((gi % 2) == 1) begin : g_odd
            assign dead_bit[gi] = WIDE_BARS[gi/2];
        end else begin : g_even
            assign dead_bit[gi] = 1'b0;
        end
    end

    always_comb begin
        rt.ch = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bar[i]) rt.ch = CH_IDX_W'(i);
        end
        rt.bad_bar = ($countones(bar) != 1) || (|(bar & dead_bit));
        rt.drop    = rt.bad_bar || (|err);
    end

endmodule

// File: rtl/rxr_route_ctl.sv
module rxr_route_ctl
    import rxr_pkg::*;
#(
    parameter int unsigned NUM_CH = 6,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              present,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [1:0]        in_err,
    input  route_t            sop_rt,
    input  logic [NUM_CH-1:0] ch_rdy,
    output logic [NUM_CH-1:0] ch_vld,
    output logic              in_wait,
    output logic              pkt_open,
    output logic [CNT_W-1:0]  bad_cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic                open_q;
    logic                drop_q;
    logic [CH_IDX_W-1:0] ch_q;
    logic [CNT_W-1:0]    cnt_q;
    route_t              eff;
    logic [NUM_CH-1:0]   tgt_oh;
    logic                accept;

    always_comb begin
        if (in_sop)
            eff = sop_rt;
        else if (open_q)
            eff = '{drop: drop_q, bad_bar: 1'b0, ch: ch_q};
        else
            eff = '{drop: 1'b1, bad_bar: 1'b0, ch: '0};
    end

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_oh
        assign tgt_oh[gi] = (eff.ch == CH_IDX_W'(gi));
    end

    assign ch_vld   = (present && !eff.drop) ? tgt_oh : '0;
    assign in_wait  = present && !eff.drop && (|(tgt_oh & ~ch_rdy));
    assign accept   = present && !in_wait;
    assign pkt_open = open_q;
    assign bad_cnt  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            drop_q <= 1'b1;
            ch_q   <= '0;
        end else if (accept) begin
            if (in_sop) begin
                open_q <= !in_eop;
                drop_q <= sop_rt.drop;
                ch_q   <= sop_rt.ch;
            end else if (in_eop) begin
                open_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (accept && in_sop && sop_rt.bad_bar && cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    AST_VLD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_vld)); // R3
    AST_ROUTE_HELD: assert property (@(posedge clk) disable iff (rst)
        (present && !in_sop && open_q && !drop_q) |-> (ch_vld == NUM_CH'(1 << ch_q))); // R4
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
        (present && in_sop && (|in_err)) |-> (ch_vld == '0 && !in_wait)); // R5
    AST_BAD_BAR_SILENT: assert property (@(posedge clk) disable iff (rst)
        (present && in_sop && sop_rt.bad_bar) |-> (ch_vld == '0)); // R6
    AST_CNT_NEVER_FALLS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt_q >= $past(cnt_q))); // R6

endmodule

// File: rtl/rxr_npmask.sv
module rxr_npmask #(
    parameter int unsigned NUM_CH  = 6,
    parameter int unsigned FILL_W  = 6,
    parameter int unsigned NP_AF   = 24,
    parameter int unsigned NP_HYST = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pkt_open,
    input  logic [NUM_CH*FILL_W-1:0] fill,
    output logic                     np_mask
);

    localparam logic [FILL_W-1:0] LVL_HI = FILL_W'(NP_AF);
    localparam logic [FILL_W-1:0] LVL_LO = FILL_W'(NP_AF - NP_HYST);

    logic [NUM_CH-1:0] at_hi;
    logic [NUM_CH-1:0] under_lo;
    logic              mask_q;

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_lvl
        assign at_hi[gi]    = fill[gi*FILL_W +: FILL_W] >= LVL_HI;
        assign under_lo[gi] = fill[gi*FILL_W +: FILL_W] <  LVL_LO;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= 1'b0;
        else if (!pkt_open) begin
            if (|at_hi)
                mask_q <= 1'b1;
            else if (&under_lo)
                mask_q <= 1'b0;
        end
    end

    assign np_mask = mask_q;

    AST_MASK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        pkt_open |=> $stable(np_mask)); // R9

endmodule

// File: rtl/rx_bar_router.sv
module rx_bar_router
    import rxr_pkg::*;
#(
    parameter int unsigned NUM_CH    = 6,
    parameter int unsigned BEAT_DW   = 8,
    parameter int unsigned FILL_W    = 6,
    parameter int unsigned NP_AF     = 24,
    parameter int unsigned NP_HYST   = 8,
    parameter int unsigned CNT_W     = 8,
    parameter logic [2:0]  WIDE_BARS = 3'b001
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_sop,
    input  logic                        in_eop,
    input  logic [BEAT_DW*DWORD_W-1:0]  in_data,
    input  logic [BEAT_DW-1:0]          in_dv,
    input  logic [NUM_CH-1:0]           in_bar,
    input  logic [1:0]                  in_err,
    output logic                        in_wait,
    output logic                        np_mask,
    input  logic [NUM_CH-1:0]           ch_rdy,
    input  logic [NUM_CH*FILL_W-1:0]    ch_np_fill,
    output logic [NUM_CH-1:0]           ch_vld,
    output logic                        out_sop,
    output logic                        out_eop,
    output logic [BEAT_DW*DWORD_W-1:0]  out_data,
    output logic [BEAT_DW-1:0]          out_dv,
    output logic                        out_np,
    output logic [CNT_W-1:0]            bad_bar_cnt
);

    localparam int unsigned NPAIR = (NUM_CH + 1) / 2;

    logic     present;
    logic     pkt_open;
    route_t   sop_rt;
    tlp_cls_e hdr_cls;

    assign present = |in_dv;
    assign hdr_cls = classify(in_data[DWORD_W-1:0]);

    rxr_bar_decode #(
        .NUM_CH    (NUM_CH),
        .NPAIR     (NPAIR),
        .WIDE_BARS (WIDE_BARS[NPAIR-1:0])
    ) u_dec (
        .bar (in_bar),
        .err (in_err),
        .rt  (sop_rt)
    );

    rxr_route_ctl #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W)
    ) u_route (
        .clk      (clk),
        .rst      (rst),
        .present  (present),
        .in_sop   (in_sop),
        .in_eop   (in_eop),
        .in_err   (in_err),
        .sop_rt   (sop_rt),
        .ch_rdy   (ch_rdy),
        .ch_vld   (ch_vld),
        .in_wait  (in_wait),
        .pkt_open (pkt_open),
        .bad_cnt  (bad_bar_cnt)
    );

    rxr_npmask #(
        .NUM_CH  (NUM_CH),
        .FILL_W  (FILL_W),
        .NP_AF   (NP_AF),
        .NP_HYST (NP_HYST)
    ) u_npm (
        .clk      (clk),
        .rst      (rst),
        .pkt_open (pkt_open),
        .fill     (ch_np_fill),
        .np_mask  (np_mask)
    );

    assign out_sop  = in_sop;
    assign out_eop  = in_eop;
    assign out_data = in_data;
    assign out_dv   = in_dv;
    assign out_np   = present && in_sop && (hdr_cls == CLS_NONPOSTED);

    AST_NP_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        out_np |-> (in_sop && (|in_dv))); // R8

endmodule

// File: tb/sim_rx_bar_router.sv
module sim_rx_bar_router;

    localparam logic [2:0] WIDE = 3'b001;
    localparam int AF = 24, HY = 8;

    logic         clk = 0;
    logic         rst = 1;
    logic         in_sop = 0, in_eop = 0;
    logic [255:0] in_data = '0;
    logic [7:0]   in_dv = '0;
    logic [5:0]   in_bar = '0;
    logic [1:0]   in_err = '0;
    logic         in_wait, np_mask, out_sop, out_eop, out_np;
    logic [5:0]   ch_rdy = '1;
    logic [35:0]  ch_np_fill;
    logic [5:0]   ch_vld;
    logic [255:0] out_data;
    logic [7:0]   out_dv;
    logic [7:0]   bad_bar_cnt;

    int  fill [6];
    int  vectors = 0, miscompares = 0;
    bit  rdy_rand = 0;
    bit  last_acc;
    bit  m_open = 0, m_drop = 1, m_mask = 0;
    int  m_ch = 0, m_cnt = 0;

    always #5 clk = ~clk;

    always_comb
        for (int i = 0; i < 6; i++) ch_np_fill[i*6 +: 6] = 6'(fill[i]);

    rx_bar_router u0 (.*);

    function automatic bit is_np(logic [31:0] h);
        logic [2:0] f = h[31:29];
        logic [4:0] t = h[28:24];
        if (t == 5'b01010 || t == 5'b01011) return 0;
        if (t[4:3] == 2'b10) return 0;
        if (t == 5'b00000 && f[1]) return 0;
        return 1;
    endfunction

    task automatic cmp(string tag, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        bit pres, drop, bad, e_wait, e_np;
        int ch, ones;
        logic [5:0] e_vld;
        string tag;
        if (rdy_rand) ch_rdy = 6'($urandom);
        #3;
        pres = |in_dv;
        ones = 0; ch = 0;
        for (int i = 0; i < 6; i++) if (in_bar[i]) begin ones++; ch = i; end
        bad = (ones != 1) || (in_bar[1] && WIDE[0]) || (in_bar[3] && WIDE[1]) || (in_bar[5] && WIDE[2]);
        if (in_sop) begin
            drop = bad || (in_err != 0);
            tag  = bad ? "R6" : ((in_err != 0) ? "R5" : "R3");
        end else if (m_open) begin
            drop = m_drop; ch = m_ch; tag = "R4";
        end else begin
            drop = 1; ch = 0; tag = "R11";
        end
        if (!pres) tag = "R2";
        e_vld  = (pres && !drop) ? 6'(1 << ch) : 6'd0;
        e_wait = pres && !drop && !ch_rdy[ch];
        e_np   = pres && in_sop && is_np(in_data[31:0]);
        cmp(tag, 64'(ch_vld), 64'(e_vld));
        cmp("R7", 64'(in_wait), 64'(e_wait));
        cmp("R8", 64'(out_np), 64'(e_np));
        cmp("R1", {54'(out_dv), out_sop, out_eop}, {54'(in_dv), in_sop, in_eop});
        cmp("R1", 64'(out_data != in_data), 64'd0);
        cmp("R6", 64'(bad_bar_cnt), 64'(m_cnt));
        cmp("R9", 64'(np_mask), 64'(m_mask));
        @(posedge clk);
        last_acc = pres && !e_wait;
        if (!m_open) begin
            bit hi = 0, lo = 1;
            for (int i = 0; i < 6; i++) begin
                if (fill[i] >= AF) hi = 1;
                if (fill[i] >= AF - HY) lo = 0;
            end
            if (hi) m_mask = 1; else if (lo) m_mask = 0;
        end
        if (last_acc) begin
            if (in_sop) begin
                m_open = !in_eop; m_drop = drop; m_ch = ch;
                if (bad && m_cnt < 255) m_cnt++;
            end else if (in_eop) m_open = 0;
        end
        #1;
    endtask

    task automatic idle(int n);
        in_dv = '0; in_sop = 0; in_eop = 0;
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic send(logic [5:0] bar, logic [1:0] err, int nb, logic [31:0] dw0, logic [5:0] bar_mid);
        for (int b = 0; b < nb; b++) begin
            in_sop  = (b == 0);
            in_eop  = (b == nb - 1);
            in_data = {8{$urandom}};
            if (b == 0) in_data[31:0] = dw0;
            in_dv   = (b == nb - 1) ? 8'(($urandom % 255) + 1) : 8'hFF;
            in_bar  = (b == 0) ? bar : bar_mid;
            in_err  = (b == 0) ? err : 2'($urandom);
            do tick(); while (!last_acc);
        end
        in_dv = '0; in_sop = 0; in_eop = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL R7 watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < 6; i++) fill[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R10: reset state
        cmp("R10", 64'(np_mask), 64'd0);
        cmp("R10", 64'(bad_bar_cnt), 64'd0);
        // R11 / R10: a continuation beat straight after reset goes nowhere
        in_sop = 0; in_eop = 1; in_dv = 8'h0F; in_bar = 6'b000001;
        tick();
        cmp("R11", 64'(ch_vld), 64'd0);
        idle(2);

        // basic routing to each usable BAR, BAR bits changing mid packet
        send(6'b000001, 2'b00, 3, 32'h4000_0001, 6'b000100);
        send(6'b000100, 2'b00, 4, 32'h0000_0001, 6'b100000);
        send(6'b001000, 2'b00, 1, 32'h4A00_0000, 6'b000001);
        send(6'b010000, 2'b00, 2, 32'h3000_0000, 6'b001000);
        send(6'b100000, 2'b00, 5, 32'h0200_0000, 6'b010000);
        // R5: error flags with every channel stalled
        ch_rdy = '0;
        send(6'b000100, 2'b01, 3, 32'h0, 6'b000100);
        send(6'b010000, 2'b10, 2, 32'h0, 6'b010000);
        ch_rdy = '1;
        // R6: unroutable codes
        send(6'b000000, 2'b00, 2, 32'h0, 6'b000001);
        send(6'b000011, 2'b00, 1, 32'h0, 6'b000001);
        send(6'b000010, 2'b00, 3, 32'h0, 6'b000001);
        idle(1);
        cmp("R6", 64'(bad_bar_cnt), 64'd3);
        // R7: back-pressure on a routed packet
        rdy_rand = 1;
        for (int k = 0; k < 10; k++) send(6'b001000, 2'b00, 4, 32'h0, 6'b000001);
        rdy_rand = 0; ch_rdy = '1;

        // R9: mask moves only between packets, with hysteresis
        in_sop = 1; in_eop = 0; in_dv = 8'hFF; in_bar = 6'b000100; in_data = '0;
        tick();
        fill[2] = 30;
        idle(4);
        cmp("R9", 64'(np_mask), 64'd0);
        in_sop = 0; in_eop = 1; in_dv = 8'h01;
        tick();
        idle(2);
        cmp("R9", 64'(np_mask), 64'd1);
        fill[2] = 20; idle(3);
        cmp("R9", 64'(np_mask), 64'd1);
        fill[2] = 15; idle(2);
        cmp("R9", 64'(np_mask), 64'd0);

        // mixed random traffic
        rdy_rand = 1;
        for (int p = 0; p < 500; p++) begin
            logic [5:0] b;
            int r = $urandom % 16;
            for (int i = 0; i < 6; i++) fill[i] = $urandom % 40;
            b = (r < 12) ? 6'(1 << ($urandom % 6)) : 6'($urandom);
            send(b, ($urandom % 8 == 0) ? 2'($urandom) : 2'b00, 1 + $urandom % 4,
                 $urandom, 6'($urandom));
            if ($urandom % 8 == 0) begin
                in_sop = 0; in_eop = $urandom; in_dv = 8'h3; in_bar = 6'b1;
                tick();
            end
            if ($urandom % 4 == 0) idle(1 + $urandom % 3);
        end
        rdy_rand = 0; ch_rdy = '1;

        // R6: saturation of the unroutable counter
        for (int k = 0; k < 260; k++) send(6'b000000, 2'b00, 1, 32'h0, 6'b0);
        idle(1);
        cmp("R6", 64'(bad_bar_cnt), 64'd255);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule